// File: doc/BRIEF.md
# Carry-Chain Condition Code Generator

This unit sits in the execute stage of an integer datapath. It handles the two arithmetic operations that take the previous carry as an input: add-with-carry and subtract-with-borrow. Each accepted operation takes two 64-bit operands, an operation select and the current 8-bit condition code register. The carry-in is bit 0 of that register. One clock edge later the unit presents the 64-bit result together with a new condition code byte. That byte holds two flag nibbles: one describes the full 64-bit result and the other describes its low 32-bit half.

In the same cycle the unit evaluates a 4-bit branch or trap test. The test reads the incoming condition code register, not the freshly computed flags, so the unit resolves a conditional branch or conditional trap that depends on earlier flags. A select input chooses whether the test reads the 32-bit or the 64-bit nibble. Register file access, instruction decode and trap delivery belong to neighbouring logic.

Top module: `ccgen_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `out_valid`, `result`, `flags_out` and `cond_true` are all zero.
- R2: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. When `in_valid` is low, `result`, `flags_out` and `cond_true` keep their previous values.
- R3: With `op_sub` = 0, `result` is `opa + opb + ccr_in[0]`, taken modulo 2^64.
- R4: With `op_sub` = 1, `result` is `opa - opb - ccr_in[0]`, taken modulo 2^64.
- R5: `flags_out[7:4]` is {N,Z,V,C} for the 64-bit result and `flags_out[3:0]` is {N,Z,V,C} for the low 32 bits. N is the top bit of its width, and Z is set when every bit of that width is zero.
- R6: For an add, the 32-bit C is the carry out of bit 31 of `opa[31:0] + opb[31:0] + ccr_in[0]`. The 64-bit C is the carry out of bit 63 of the full sum.
- R7: For an add, V at width w is set when `opa` and `opb` have the same bit w-1 and the result's bit w-1 differs from it, for w = 32 and w = 64.
- R8: For a subtract, V at width w is set when bit w-1 of `opa` differs from bit w-1 of `opb` and the result's bit w-1 differs from that of `opa`.
- R9: For a subtract, let t = (`opb` + `ccr_in[0]`) modulo 2^64. C at width w is the inverse of the carry out of `opa` + ~t + 1 over the low w bits. This is equivalent to an unsigned `opa` < t at that width. So when `opb` is all ones and the carry-in is 1, both C flags are 0.
- R10: The condition test reads `ccr_in[3:0]` when `cond_wide` = 0 and `ccr_in[7:4]` when `cond_wide` = 1, never the newly computed flags. The outcome appears on `cond_true` with the result.
- R11: With {N,Z,V,C} the selected nibble, `cond_sel` codes give: 0 never, 1 Z, 2 Z|(N^V), 3 N^V, 4 C|Z, 5 C, 6 N, 7 V. Codes 8 to 15 are the complements of codes 0 to 7 in order, so 8 is always.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op_sub | input | 1 | 0 add-with-carry, 1 subtract-with-borrow |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| ccr_in | input | 8 | Current condition code register; bit 0 is carry-in |
| cond_wide | input | 1 | Condition nibble select: 0 low, 1 high |
| cond_sel | input | 4 | Branch/trap condition code |
| out_valid | output | 1 | Registered result valid |
| result | output | 64 | Registered arithmetic result |
| flags_out | output | 8 | New condition codes {N,Z,V,C}x2 |
| cond_true | output | 1 | Condition evaluation outcome |

## Verification
The hardest case to reach is the subtract where the operand plus the borrow wraps to zero, because random 64-bit operands almost never make `opb` all ones while bit 0 of the condition register is also set. The stimulus covers it with directed vectors: all-ones operands with the borrow set, and a low half of all ones with a different upper half, so that the two carry widths are checked separately. Carries across the 32-bit boundary, both signed overflow edges and a sweep of every condition code over both nibbles fill in the rest. A few hundred random operations round out the stimulus.

// File: rtl/ccgen_pkg.sv
package ccgen_pkg;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } nzvc_t;

  typedef enum logic [2:0] {
    TST_NEVER = 3'd0,
    TST_EQ    = 3'd1,
    TST_LE    = 3'd2,
    TST_LT    = 3'd3,
    TST_LEU   = 3'd4,
    TST_CS    = 3'd5,
    TST_NEG   = 3'd6,
    TST_VS    = 3'd7
  } test_e;

  // Upper code bit inverts the base test (code 8 = always).
  function automatic logic cond_eval(input nzvc_t f, input logic [3:0] sel);
    logic base;
    case (test_e'(sel[2:0]))
      TST_NEVER: base = 1'b0;
      TST_EQ:    base = f.z;
      TST_LE:    base = f.z | (f.n ^ f.v);
      TST_LT:    base = f.n ^ f.v;
      TST_LEU:   base = f.c | f.z;
      TST_CS:    base = f.c;
      TST_NEG:   base = f.n;
      default:   base = f.v;
    endcase
    return base ^ sel[3];
  endfunction

endpackage

// File: rtl/ccgen_adder.sv
module ccgen_adder #(
  parameter int W = 64,
  parameter int H = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         c_hi,
  output logic         c_lo
);
  localparam int WP = W + 1;
  localparam int HP = H + 1;

  logic [W-1:0]  addend;
  logic          ci;
  logic [WP-1:0] full;
  logic [HP-1:0] low;

  // Subtract folds the borrow into the subtrahend before inverting it,
  // so a wrapped (b + cin) yields no borrow.
  always_comb begin
    if (sub) begin
      addend = ~(b + W'(cin));
      ci     = 1'b1;
    end else begin
      addend = b;
      ci     = cin;
    end
    full = {1'b0, a} + {1'b0, addend} + WP'(ci);
    low  = {1'b0, a[H-1:0]} + {1'b0, addend[H-1:0]} + HP'(ci);
    sum  = full[W-1:0];
    c_hi = full[W] ^ sub;
    c_lo = low[H] ^ sub;
  end
endmodule

// File: rtl/ccgen_lane.sv
module ccgen_lane
  import ccgen_pkg::*;
#(
  parameter int LW = 32
) (
  input  logic          a_msb,
  input  logic          b_msb,
  input  logic [LW-1:0] sum,
  input  logic          carry,
  input  logic          sub,
  output nzvc_t         flags
);
  logic r_msb;

  always_comb begin
    r_msb   = sum[LW-1];
    flags.n = r_msb;
    flags.z = ~|sum;
    flags.c = carry;
    if (sub) flags.v = (a_msb != b_msb) && (r_msb != a_msb);
    else     flags.v = (a_msb == b_msb) && (r_msb != a_msb);
  end
endmodule

// File: rtl/ccgen_cond.sv
module ccgen_cond
  import ccgen_pkg::*;
(
  input  logic [7:0] ccr,
  input  logic       wide,
  input  logic [3:0] sel,
  output logic       hit
);
  nzvc_t nib;

  always_comb begin
    nib = wide ? nzvc_t'(ccr[7:4]) : nzvc_t'(ccr[3:0]);
    hit = cond_eval(nib, sel);
  end
endmodule

// File: rtl/ccgen_unit.sv
module ccgen_unit
  import ccgen_pkg::*;
#(
  parameter int W = 64,
  parameter int H = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         op_sub,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [7:0]   ccr_in,
  input  logic         cond_wide,
  input  logic [3:0]   cond_sel,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic [7:0]   flags_out,
  output logic         cond_true
);
  localparam int NLANE = 2;

  logic [W-1:0]     sum;
  logic             c_hi, c_lo;
  logic [NLANE-1:0] carry;
  nzvc_t            lane_f [NLANE];
  logic             hit;

  ccgen_adder #(.W(W), .H(H)) u_adder (
    .a(opa), .b(opb), .cin(ccr_in[0]), .sub(op_sub),
    .sum(sum), .c_hi(c_hi), .c_lo(c_lo)
  );

  assign carry = {c_hi, c_lo};

  // Lane 0 covers the low half, lane 1 the full width.
  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    localparam int LW = (k == 0) ? H : W;
    ccgen_lane #(.LW(LW)) u_lane (
      .a_msb(opa[LW-1]), .b_msb(opb[LW-1]), .sum(sum[LW-1:0]),
      .carry(carry[k]), .sub(op_sub), .flags(lane_f[k])
    );
  end

  ccgen_cond u_cond (
    .ccr(ccr_in), .wide(cond_wide), .sel(cond_sel), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags_out <= '0;
      cond_true <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= sum;
        flags_out <= {lane_f[1], lane_f[0]};
        cond_true <= hit;
      end
    end
  end
endmodule

// File: rtl/ccgen_unit_chk.sv
module ccgen_unit_chk #(
  parameter int W = 64,
  parameter int H = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         op_sub,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [7:0]   ccr_in,
  input logic         cond_wide,
  input logic [3:0]   cond_sel,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic [7:0]   flags_out,
  input logic         cond_true
);
  AST_RESET_CLEAR: assert property (@(posedge clk) $past(rst) |-> (!out_valid && result == '0 && flags_out == '0 && !cond_true)); // R1
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst) !$past(rst) |-> out_valid == $past(in_valid)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && !$past(in_valid)) |-> ($stable(result) && $stable(flags_out) && $stable(cond_true))); // R2
  AST_ADD_SUM: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(in_valid && !op_sub)) |-> result == $past(opa + opb + W'(ccr_in[0]))); // R3
  AST_SUB_DIFF: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(in_valid && op_sub)) |-> result == $past(opa - opb - W'(ccr_in[0]))); // R4
  AST_ZERO_WIDE: assert property (@(posedge clk) disable iff (rst) out_valid |-> flags_out[6] == (result == '0)); // R5
  AST_ZERO_NARROW: assert property (@(posedge clk) disable iff (rst) out_valid |-> flags_out[2] == (result[H-1:0] == '0)); // R5
  AST_NEG_BITS: assert property (@(posedge clk) disable iff (rst) out_valid |-> (flags_out[7] == result[W-1] && flags_out[3] == result[H-1])); // R5
  AST_COND_NEVER: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(in_valid && cond_sel == 4'h0)) |-> !cond_true); // R11
  AST_COND_ALWAYS: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(in_valid && cond_sel == 4'h8)) |-> cond_true); // R11
  AST_COND_CARRY: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(in_valid && cond_sel == 4'h5)) |-> cond_true == $past(cond_wide ? ccr_in[4] : ccr_in[0])); // R10
endmodule

bind ccgen_unit ccgen_unit_chk #(.W(W), .H(H)) u_chk (.*);

// File: tb/ccgen_unit_bench.sv
`timescale 1ns/1ps
module ccgen_unit_bench;
  localparam int W = 64;
  localparam int H = 32;

  typedef struct {
    logic [63:0] res;
    logic [7:0]  fl;
    logic        ct;
    logic        sub;
  } exp_t;

  logic        clk = 0;
  logic        rst = 1;
  logic        in_valid = 0;
  logic        op_sub = 0;
  logic [63:0] opa = '0;
  logic [63:0] opb = '0;
  logic [7:0]  ccr_in = '0;
  logic        cond_wide = 0;
  logic [3:0]  cond_sel = '0;
  logic        out_valid;
  logic [63:0] result;
  logic [7:0]  flags_out;
  logic        cond_true;

  int checks = 0;
  int errors = 0;
  exp_t q[$];
  logic [63:0] last_res = '0;
  logic [7:0]  last_fl = '0;

  always #10 clk = ~clk;

  ccgen_unit #(.W(W), .H(H)) u_ccgen_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sub(op_sub),
    .opa(opa), .opb(opb), .ccr_in(ccr_in), .cond_wide(cond_wide),
    .cond_sel(cond_sel), .out_valid(out_valid), .result(result),
    .flags_out(flags_out), .cond_true(cond_true)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R11 code table
  function automatic bit exp_cond(input logic [3:0] nib, input logic [3:0] code);
    bit n, z, v, c;
    {n, z, v, c} = nib;
    case (code)
      4'd0:  return 0;
      4'd1:  return z;
      4'd2:  return z | (n ^ v);
      4'd3:  return n ^ v;
      4'd4:  return c | z;
      4'd5:  return c;
      4'd6:  return n;
      4'd7:  return v;
      4'd8:  return 1;
      4'd9:  return !z;
      4'd10: return !(z | (n ^ v));
      4'd11: return !(n ^ v);
      4'd12: return !(c | z);
      4'd13: return !c;
      4'd14: return !n;
      default: return !v;
    endcase
  endfunction

  task automatic send(input logic s, input logic [63:0] a, input logic [63:0] b,
                      input logic [7:0] ccr, input logic wide, input logic [3:0] sel);
    exp_t e;
    logic        cin;
    logic [64:0] s65;
    logic [32:0] s33;
    logic [63:0] t, r;
    logic        c64, c32, v64, v32;
    cin = ccr[0];
    if (!s) begin
      s65 = {1'b0, a} + {1'b0, b} + 65'(cin);               // R3, R6
      s33 = {1'b0, a[31:0]} + {1'b0, b[31:0]} + 33'(cin);
      r = s65[63:0]; c64 = s65[64]; c32 = s33[32];
      v64 = (a[63] == b[63]) && (r[63] != a[63]);            // R7
      v32 = (a[31] == b[31]) && (r[31] != a[31]);
    end else begin
      t = b + 64'(cin);                                      // R9: wraps
      r = a - b - 64'(cin);                                  // R4
      c64 = a < t;
      c32 = a[31:0] < t[31:0];
      v64 = (a[63] != b[63]) && (r[63] != a[63]);            // R8
      v32 = (a[31] != b[31]) && (r[31] != a[31]);
    end
    e.res = r;
    e.fl  = {r[63], r == 64'd0, v64, c64, r[31], r[31:0] == 32'd0, v32, c32};
    e.ct  = exp_cond(wide ? ccr[7:4] : ccr[3:0], sel);     // R10
    e.sub = s;
    @(negedge clk);
    in_valid = 1; op_sub = s; opa = a; opb = b; ccr_in = ccr;
    cond_wide = wide; cond_sel = sel;
    q.push_back(e);
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        if (q.size() == 0) begin
          chk(0, "R2 unexpected out_valid", 64'(out_valid), 64'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(result == e.res, e.sub ? "R4 result" : "R3 result", result, e.res);
          chk({flags_out[7:6], flags_out[3:2]} == {e.fl[7:6], e.fl[3:2]}, "R5 N/Z", 64'(flags_out), 64'(e.fl));
          chk({flags_out[4], flags_out[0]} == {e.fl[4], e.fl[0]}, e.sub ? "R9 carry" : "R6 carry", 64'(flags_out), 64'(e.fl));
          chk({flags_out[5], flags_out[1]} == {e.fl[5], e.fl[1]}, e.sub ? "R8 overflow" : "R7 overflow", 64'(flags_out), 64'(e.fl));
          chk(cond_true == e.ct, "R10/R11 condition", 64'(cond_true), 64'(e.ct));
          last_res = e.res;
          last_fl  = e.fl;
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && result == 0 && flags_out == 0 && !cond_true, "R1 reset state",
        {out_valid, cond_true, flags_out, result[53:0]}, 64'd0);
    rst = 0;
    @(negedge clk);
    chk(!out_valid && result == 0 && flags_out == 0, "R1 after reset", result, 64'd0);

    // R3/R6 directed adds
    send(0, 64'd5, 64'd7, 8'h00, 0, 4'd8);
    send(0, 64'h0000_0000_FFFF_FFFF, 64'd0, 8'h01, 0, 4'd1);          // R6 low carry, low Z
    send(0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 8'h01, 1, 4'd5);          // R6 full carry, Z
    send(0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 8'h01, 0, 4'd7);          // R7 64-bit overflow
    send(0, 64'h0000_0000_7FFF_FFFF, 64'd1, 8'h00, 1, 4'd3);          // R7 32-bit overflow
    send(0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 8'h00, 0, 4'd0); // R7
    // R4/R8/R9 directed subtracts
    send(1, 64'd10, 64'd3, 8'h01, 0, 4'd9);
    send(1, 64'd3, 64'd10, 8'h00, 1, 4'd13);                           // borrow
    send(1, 64'h8000_0000_0000_0000, 64'd1, 8'h00, 0, 4'd2);          // R8 overflow
    send(1, 64'h0000_0000_8000_0000, 64'd1, 8'h00, 0, 4'd4);          // R8 32-bit
    send(1, 64'h1234, 64'hFFFF_FFFF_FFFF_FFFF, 8'h01, 0, 4'd6);       // R9 wrap corner
    send(1, 64'h0, 64'h0000_0005_FFFF_FFFF, 8'h01, 1, 4'd12);         // R9 low-half wrap
    send(1, 64'd0, 64'd0, 8'h01, 0, 4'd10);                            // 0-0-1
    send(1, 64'd7, 64'd7, 8'h00, 1, 4'd1);

    // R10/R11 sweep: every code, both nibbles, several flag patterns
    for (int p = 0; p < 16; p++) begin
      for (int code = 0; code < 16; code++) begin
        send(0, 64'd1, 64'd2, {4'(p), 4'(15 - p)}, 1'(code), 4'(code));
        send(1, 64'd9, 64'd4, {4'(15 - p), 4'(p)}, 1'(~code[0]), 4'(code));
      end
    end

    // Random mix with occasional idle cycles
    for (int i = 0; i < 300; i++) begin
      send(1'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
           8'($urandom), 1'($urandom), 4'($urandom));
      if (($urandom % 5) == 0) begin
        @(negedge clk);
        in_valid = 0;
      end
    end

    @(negedge clk);
    in_valid = 0;
    opa = '1; opb = '1; ccr_in = 8'hFF; cond_sel = 4'd8;
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R2 all results seen", 64'(q.size()), 64'd0);
    chk(!out_valid, "R2 out_valid low when idle", 64'(out_valid), 64'd0);
    chk(result == last_res && flags_out == last_fl, "R2 outputs held when idle", result, last_res);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule